// File: doc/BRIEF.md
# Address-Translation Control Register File

This block is the software-visible register file that sits beside an address-translation unit. It holds nine 32-bit registers: a translation control word, the high, low and assist halves of a page-table entry being loaded, the table base pointer, the faulting address, and three event-code registers (trap code, exception event, interrupt event). A bus master reads and writes them through a simple single-cycle request port. A read response appears in the same cycle as the request.

Two writes have side effects that the translation unit consumes directly. Setting the invalidate bit in the control word drops a one-cycle invalidate-all pulse, and the bit itself is never stored. Writing the entry-high register with an address-space identifier (its low 8 bits) that differs from the stored one drops a one-cycle flush pulse. Several registers keep only a narrow low field of what is written. Accesses that are not full 32-bit words, or that fall on an unused or misaligned offset, are refused with an error flag.

Top module: `mmu_ctl_regs`

## Requirements
- R1: A word write to offset 0x00 (control) with wdata bit 2 set raises `tlb_inval_pulse` in that same cycle. The stored control value is wdata with bit 2 forced to 0, so bit 2 always reads back 0 and all other bits read back as written.
- R2: A word write to offset 0x04 (entry high) stores all 32 bits. It raises `asid_flush_pulse` in that same cycle only when wdata[7:0] differs from the stored bits [7:0].
- R3: Offset 0x0C (entry assist) keeps wdata[3:0]. Bits 31:4 read as 0.
- R4: Offsets 0x18 (trap code), 0x1C (exception event) and 0x20 (interrupt event) each keep wdata[10:0]. Bits 31:11 read as 0.
- R5: Offsets 0x08 (entry low), 0x10 (table base) and 0x14 (fault address) store and read back all 32 bits.
- R6: Only `acc_size` = 2 (32-bit) is accepted. Sizes 0 (byte), 1 (half) and 3 give `acc_err`=1 and `acc_rdata`=0, change no register, and raise no pulse.
- R7: A word access whose offset is misaligned (bits 1:0 nonzero) or at or above 0x24 gives `acc_err`=1 and `acc_rdata`=0, and changes no register.
- R8: Each pulse is high only in a cycle that carries an accepted write of its register. Reads, refused accesses and idle cycles never pulse.
- R9: After reset every register reads 0 and both pulses are low.
- R10: `acc_rdata` carries the addressed register during an accepted read in the request cycle, and is 0 in every other cycle. `acc_err` is 0 whenever `acc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 6 | Byte offset of the register |
| acc_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, same cycle as the request |
| acc_err | output | 1 | Access refused (bad size or offset) |
| tlb_inval_pulse | output | 1 | One-cycle invalidate-all command |
| asid_flush_pulse | output | 1 | One-cycle flush on identifier change |

## Verification
All-ones writes to every offset show which bits each register keeps and which it drops. A following write of zeros then shows that no stale bits survive. Control writes with and without bit 2 tell the invalidate command apart from an ordinary store. Entry-high writes that repeat the identifier byte while changing the upper bits, followed by writes that change only the identifier, tell the flush comparison apart from a plain "any write" trigger. Byte, half and reserved-size accesses, plus misaligned and out-of-range offsets, are each followed by a read-back, which shows that refused accesses leave the state intact. A long mixed run then compares every output on every cycle against the bench's model.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;

  localparam int unsigned NUM_REGS = 9;
  localparam int unsigned ID_W     = 4;

  typedef enum logic [ID_W-1:0] {
    RG_CTRL  = 4'd0,
    RG_PTEH  = 4'd1,
    RG_PTEL  = 4'd2,
    RG_PTEA  = 4'd3,
    RG_TBASE = 4'd4,
    RG_FAULT = 4'd5,
    RG_TRAP  = 4'd6,
    RG_EXC   = 4'd7,
    RG_INT   = 4'd8
  } reg_id_e;

  localparam logic [1:0] SZ_WORD = 2'd2;

  // Mask with the w lowest bits set.
  function automatic logic [31:0] low_ones(input int unsigned w);
    if (w >= 32) return '1;
    return (32'd1 << w) - 32'd1;
  endfunction

  // Bits a register keeps from a write.
  function automatic logic [31:0] store_mask(input reg_id_e id,
                                             input int unsigned inv_bit,
                                             input int unsigned asst_w,
                                             input int unsigned code_w);
    case (id)
      RG_CTRL:                 return ~(32'd1 << inv_bit);
      RG_PTEA:                 return low_ones(asst_w);
      RG_TRAP, RG_EXC, RG_INT: return low_ones(code_w);
      default:                 return '1;
    endcase
  endfunction

  // Identifier comparison used for the flush decision.
  function automatic logic ident_differs(input logic [7:0] nxt,
                                         input logic [7:0] cur);
    return nxt != cur;
  endfunction

endpackage

// File: rtl/mmu_reg_decode.sv
module mmu_reg_decode
  import mmu_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit,
  output logic              err,
  output reg_id_e           id
);
  localparam int unsigned SLOT_W = ADDR_W - 2;

  logic [SLOT_W-1:0] slot;
  logic              aligned;
  logic              in_range;

  assign slot     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = (slot < SLOT_W'(NUM_REGS));
  assign hit      = valid && (size == SZ_WORD) && aligned && in_range;
  assign err      = valid && !hit;
  assign id       = reg_id_e'(slot[ID_W-1:0]);

  always_comb begin
    if (!valid) a_no_err_idle_r10: assert (!err);
  end
endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
  import mmu_regs_pkg::*;
#(
  parameter int unsigned INV_BIT = 2,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned ASST_W  = 4,
  parameter int unsigned CODE_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_id_e           id,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [ASID_W-1:0] asid_q
);
  logic [31:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam reg_id_e     RID  = reg_id_e'(ID_W'(g));
    localparam logic [31:0] KEEP = store_mask(RID, INV_BIT, ASST_W, CODE_W);
    always_ff @(posedge clk) begin
      if (!rst_n)                   regs_q[g] <= '0;
      else if (wr_en && id == RID)  regs_q[g] <= wdata & KEEP;
    end
  end

  assign rdata  = rd_en ? regs_q[id] : '0;
  assign asid_q = regs_q[RG_PTEH][ASID_W-1:0];

  p_ctrl_inv_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && id == RG_CTRL) |-> !rdata[INV_BIT]);
  p_asst_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && id == RG_PTEA) |-> (rdata[31:ASST_W] == '0));
  p_code_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (id == RG_TRAP || id == RG_EXC || id == RG_INT))
      |-> (rdata[31:CODE_W] == '0));
endmodule

// File: rtl/mmu_side_fx.sv
module mmu_side_fx
  import mmu_regs_pkg::*;
#(
  parameter int unsigned INV_BIT = 2,
  parameter int unsigned ASID_W  = 8
) (
  input  logic              wr_en,
  input  reg_id_e           id,
  input  logic [31:0]       wdata,
  input  logic [ASID_W-1:0] asid_q,
  output logic              inval,
  output logic              flush
);
  assign inval = wr_en && (id == RG_CTRL) && wdata[INV_BIT];
  assign flush = wr_en && (id == RG_PTEH) &&
                 ident_differs(8'(wdata[ASID_W-1:0]), 8'(asid_q));
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_regs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned INV_BIT = 2,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned ASST_W  = 4,
  parameter int unsigned CODE_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              acc_err,
  output logic              tlb_inval_pulse,
  output logic              asid_flush_pulse
);
  logic              acc_hit;
  reg_id_e           acc_id;
  logic              wr_accept;
  logic              rd_accept;
  logic [ASID_W-1:0] asid_q;

  mmu_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid(acc_valid), .addr(acc_addr), .size(acc_size),
    .hit(acc_hit), .err(acc_err), .id(acc_id)
  );

  assign wr_accept = acc_hit && acc_write;
  assign rd_accept = acc_hit && !acc_write;

  mmu_reg_bank #(
    .INV_BIT(INV_BIT), .ASID_W(ASID_W), .ASST_W(ASST_W), .CODE_W(CODE_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_accept), .rd_en(rd_accept),
    .id(acc_id), .wdata(acc_wdata), .rdata(acc_rdata), .asid_q(asid_q)
  );

  mmu_side_fx #(.INV_BIT(INV_BIT), .ASID_W(ASID_W)) u_fx (
    .wr_en(wr_accept), .id(acc_id), .wdata(acc_wdata), .asid_q(asid_q),
    .inval(tlb_inval_pulse), .flush(asid_flush_pulse)
  );

  p_flush_moves_asid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    asid_flush_pulse |=> (asid_q != $past(asid_q)));
  p_same_asid_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && acc_id == RG_PTEH && !asid_flush_pulse) |=> $stable(asid_q));
  p_bad_size_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_size != SZ_WORD)
      |-> (acc_err && !tlb_inval_pulse && !asid_flush_pulse));
  p_err_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (acc_rdata == '0));
  p_pulse_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_inval_pulse || asid_flush_pulse)
      |-> (acc_valid && acc_write && !acc_err));
  p_pulses_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tlb_inval_pulse, asid_flush_pulse}));
  p_idle_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (acc_rdata == '0 && !acc_err));
endmodule

// File: tb/mmu_ctl_regs_tb.sv
module mmu_ctl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [5:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_err;
  logic        tlb_inval_pulse;
  logic        asid_flush_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] model [0:8];

  always #10 clk = ~clk;

  mmu_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_err(acc_err),
    .tlb_inval_pulse(tlb_inval_pulse), .asid_flush_pulse(asid_flush_pulse)
  );

  // Bits each offset keeps, written from the requirements.
  function automatic logic [31:0] keep_bits(input int slot);
    case (slot)
      0:       return 32'hFFFF_FFFB;            // R1 control, bit 2 dropped
      3:       return 32'h0000_000F;            // R3 assist
      6, 7, 8: return 32'h0000_07FF;            // R4 event codes
      default: return 32'hFFFF_FFFF;            // R2, R5 full width
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  // One clock: drive, compare mid-cycle against the model, then advance it.
  task automatic step(input string tag, input bit v, input bit w,
                      input logic [5:0] a, input logic [1:0] sz,
                      input logic [31:0] d);
    bit ok;
    int slot;
    logic [31:0] e_rd;
    bit e_err, e_inv, e_fl;
    @(posedge clk);
    #5;
    acc_valid = v; acc_write = w; acc_addr = a; acc_size = sz; acc_wdata = d;
    slot = int'(a) / 4;
    ok = v && (sz == 2'd2) && (a % 4 == 0) && (slot < 9);
    e_err = v && !ok;
    e_rd  = (ok && !w) ? model[slot] : 32'h0;
    e_inv = ok && w && (slot == 0) && d[2];
    e_fl  = ok && w && (slot == 1) && (d[7:0] != model[1][7:0]);
    #10;
    chk(tag, "rdata", acc_rdata, e_rd);
    chk(tag, "err", {31'b0, acc_err}, {31'b0, e_err});
    chk(tag, "inval", {31'b0, tlb_inval_pulse}, {31'b0, e_inv});
    chk(tag, "flush", {31'b0, asid_flush_pulse}, {31'b0, e_fl});
    if (ok && w) model[slot] = d & keep_bits(slot);
  endtask

  task automatic wr(input string tag, input logic [5:0] a, input logic [31:0] d);
    step(tag, 1, 1, a, 2'd2, d);
  endtask

  task automatic rd(input string tag, input logic [5:0] a);
    step(tag, 1, 0, a, 2'd2, 32'h0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;

    // R9: reset values, pulses low
    for (int i = 0; i < 9; i++) rd("R9", 6'(i * 4));
    step("R10", 0, 0, 6'h00, 2'd2, 32'h0);

    // Full-width ones to every register: R1 R2 R3 R4 R5
    for (int i = 0; i < 9; i++) wr("R5", 6'(i * 4), 32'hFFFF_FFFF);
    for (int i = 0; i < 9; i++) rd("R3", 6'(i * 4));
    for (int i = 0; i < 9; i++) wr("R4", 6'(i * 4), 32'h0);
    for (int i = 0; i < 9; i++) rd("R4", 6'(i * 4));

    // R1: invalidate bit alone, and a control write without it
    wr("R1", 6'h00, 32'h0000_0004);
    rd("R1", 6'h00);
    wr("R1", 6'h00, 32'h1234_5AF1);
    rd("R1", 6'h00);

    // R2: same identifier with new upper bits, then a new identifier
    wr("R2", 6'h04, 32'hABCD_0000);
    wr("R2", 6'h04, 32'hABCD_0055);
    wr("R2", 6'h04, 32'h0000_0055);
    wr("R2", 6'h04, 32'h0000_0056);
    rd("R2", 6'h04);

    // R6: refused sizes leave state intact, no pulses
    wr("R5", 6'h10, 32'hCAFE_F00D);
    step("R6", 1, 1, 6'h10, 2'd0, 32'h1111_1111);
    step("R6", 1, 1, 6'h10, 2'd1, 32'h2222_2222);
    step("R6", 1, 1, 6'h00, 2'd3, 32'h0000_0004);
    step("R6", 1, 1, 6'h04, 2'd1, 32'h0000_00AA);
    step("R6", 1, 0, 6'h10, 2'd0, 32'h0);
    rd("R6", 6'h10);
    rd("R6", 6'h04);

    // R7: misaligned and unused offsets
    step("R7", 1, 1, 6'h05, 2'd2, 32'hFFFF_FFFF);
    step("R7", 1, 1, 6'h24, 2'd2, 32'hFFFF_FFFF);
    step("R7", 1, 0, 6'h3C, 2'd2, 32'h0);
    step("R7", 1, 0, 6'h12, 2'd2, 32'h0);
    rd("R7", 6'h04);

    // R8: back-to-back pulses, reads and idle never pulse
    wr("R8", 6'h00, 32'h4);
    wr("R8", 6'h00, 32'h4);
    wr("R8", 6'h04, 32'h01);
    wr("R8", 6'h04, 32'h02);
    step("R8", 0, 1, 6'h00, 2'd2, 32'h4);
    step("R8", 1, 0, 6'h00, 2'd2, 32'h4);

    // Mixed run across all requirements
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(0, 9));
      logic [5:0] a = (r < 7) ? 6'($urandom_range(0, 8) * 4) : 6'($urandom_range(0, 63));
      logic [1:0] sz = (r == 9) ? 2'($urandom_range(0, 3)) : 2'd2;
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 3) == 0) d[7:0] = model[1][7:0];
      step("R10", $urandom_range(0, 5) != 0, $urandom_range(0, 1) == 1, a, sz, d);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule